// File: doc/BRIEF.md
# Relay Channel Controller with Background Contact Check

This block runs four single-pole changeover relay channels from a small register port. The host writes a command word, and each channel drives its coil towards the set (closed, normally-open path made) or reset (open, normally-closed path made) position. Each relay also has a second, auxiliary contact that follows the main one. The block filters that contact for bounce and, in the background, checks it against the command.

After any change of command there is a settle window, so that a relay that is still moving is not reported. Once the window has passed, any disagreement sets a sticky fault bit for that channel. That bit raises the interrupt only when the channel is enabled. A parameter picks how the coils are driven. In level mode the set line is held for as long as the channel is set, and every channel starts de-energized. In pulse mode each change of command gives one timed set or reset pulse, which suits magnetically latching relays; nothing is pulsed at start-up.

The host sees four registers on a two-bit address: command (0), debounced position (1), fault status (2) and interrupt enable (3). Read data is registered, so every read is a single-cycle snapshot. A command write first lands in a holding register and moves to the channels as one word on the following clock.

Top module: `relay_bit_ctrl`

## Requirements
- R1: A write to address 0 uses only bits 3:0, with bit 0 as channel 1 up to bit 3 as channel 4. Bits 15:4 are discarded. A read of address 0 returns the active command in bits 3:0, and its upper bits read 0.
- R2: In level mode, coil_set of a channel is 1 exactly while its active command is 1, and coil_rst stays 0. After reset every channel is commanded 0 and de-energized.
- R3: In pulse mode, a change of a channel's command gives one pulse of PULSE_CYC cycles: on coil_set for a change to 1, or on coil_rst for a change to 0. Rewriting an unchanged value and leaving reset both give no pulse.
- R4: The auxiliary contact input of each channel is synchronized and accepted only after DEB_CYC consecutive cycles at a new level. A shorter excursion leaves the debounced position unchanged.
- R5: A read of address 1 returns the debounced position of each channel in bits 3:0, with bits 15:4 as 0.
- R6: Once SETTLE_CYC cycles have passed since reset or since the channel's last command change, a debounced position that differs from the active command sets that channel's fault bit. Within the window no fault is set.
- R7: Fault bits, read at address 2, stay set until a write to address 2 with a 1 in the bit position clears them. A 0 in a bit position leaves that bit unchanged. A fault that is still present sets the bit again.
- R8: Address 3 holds the per-channel interrupt enables in bits 3:0. irq is 1 exactly when some channel has both its fault bit and its enable bit set.
- R9: A command written at one clock edge reaches the channel outputs at the next edge, all four bits together. A read returns the addressed register as it was at the clock edge where rd_addr was sampled.
- R10: coil_set and coil_rst of one channel are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register select, sampled each cycle |
| rd_data | output | 16 | Registered read data |
| aux_in | input | 4 | Auxiliary contact inputs, 1 = closed (set) |
| coil_set | output | 4 | Coil drive towards set, per channel |
| coil_rst | output | 4 | Coil drive towards reset, per channel |
| irq | output | 1 | Interrupt, OR of enabled faults |

## Verification
The command path is swept over all sixteen channel patterns, each with different junk in the ignored upper bits. This separates a correct bit-to-channel mapping from shifted or masked-wrong ones. Running the sweep in order covers every single-bit and multi-bit transition, so pulse counts per channel in pulse mode show the pulse direction, the width and the absence of a pulse for bits that do not change. The position register is swept over all sixteen contact patterns, and a short bounce is injected to show the filter holding. The fault logic is tried with a contact that follows late but inside the settle window, one that never follows, and one mismatch on an enabled channel next to one on a masked channel. Together these show suppression, detection, stickiness, clear-on-one and interrupt masking.

// File: rtl/relay_pkg.sv
package relay_pkg;
    localparam int NUM_CH = 4;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        REG_CMD   = 2'd0,
        REG_STATE = 2'd1,
        REG_FAULT = 2'd2,
        REG_INTEN = 2'd3
    } reg_sel_e;

    typedef enum logic {
        DRIVE_LEVEL = 1'b0,
        DRIVE_PULSE = 1'b1
    } drive_mode_e;

    typedef struct packed {
        logic [NUM_CH-1:0] cmd;
        logic [NUM_CH-1:0] pos;
        logic [NUM_CH-1:0] fault;
        logic [NUM_CH-1:0] inten;
    } chan_view_t;

    function automatic logic [WORD_W-1:0] widen(input logic [NUM_CH-1:0] v);
        return {{(WORD_W-NUM_CH){1'b0}}, v};
    endfunction
endpackage

// File: rtl/relay_debounce.sv
module relay_debounce #(
    parameter int DEB_CYC = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic pos_o
);
    localparam int CW = $clog2(DEB_CYC + 1);

    logic          s1_q, s2_q, deb_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q  <= 1'b0;
            s2_q  <= 1'b0;
            deb_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            s1_q <= raw_i;
            s2_q <= s1_q;
            if (s2_q == deb_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(DEB_CYC - 1)) begin
                deb_q <= s2_q;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pos_o = deb_q;

    // R4: a new position is only ever the synchronized level just seen
    p_deb_from_sync_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(deb_q) |-> deb_q == $past(s2_q));
endmodule

// File: rtl/relay_coil_drv.sv
module relay_coil_drv import relay_pkg::*; #(
    parameter drive_mode_e MODE      = DRIVE_LEVEL,
    parameter int          PULSE_CYC = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_i,
    input  logic chg_i,
    input  logic new_i,
    output logic set_o,
    output logic rst_o
);
    generate
        if (MODE == DRIVE_LEVEL) begin : g_level
            assign set_o = cmd_i;
            assign rst_o = 1'b0;
        end else begin : g_pulse
            localparam int PW = $clog2(PULSE_CYC + 1);
            logic [PW-1:0] left_q;
            logic          dir_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    left_q <= '0;
                    dir_q  <= 1'b0;
                end else if (chg_i) begin
                    left_q <= PW'(PULSE_CYC);
                    dir_q  <= new_i;
                end else if (left_q != '0) begin
                    left_q <= left_q - 1'b1;
                end
            end

            assign set_o = (left_q != '0) && dir_q;
            assign rst_o = (left_q != '0) && !dir_q;

            // R3: pulse direction agrees with the command now in force
            p_set_dir_r3: assert property (@(posedge clk) disable iff (rst)
                set_o |-> cmd_i);
            p_rst_dir_r3: assert property (@(posedge clk) disable iff (rst)
                rst_o |-> !cmd_i);
            // R3: a pulse only starts after a command change
            p_no_spur_r3: assert property (@(posedge clk) disable iff (rst)
                $rose(set_o || rst_o) |-> $past(chg_i));
        end
    endgenerate
endmodule

// File: rtl/relay_bit_chan.sv
module relay_bit_chan #(
    parameter int SETTLE_CYC = 60000
) (
    input  logic clk,
    input  logic rst,
    input  logic chg_i,
    input  logic cmd_i,
    input  logic pos_i,
    input  logic clr_i,
    output logic fault_o
);
    localparam int SW = $clog2(SETTLE_CYC + 1);

    logic [SW-1:0] settle_q;
    logic          fault_q;
    logic          miss;

    assign miss = (settle_q == '0) && (pos_i != cmd_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            settle_q <= SW'(SETTLE_CYC);
            fault_q  <= 1'b0;
        end else begin
            if (chg_i)
                settle_q <= SW'(SETTLE_CYC);
            else if (settle_q != '0)
                settle_q <= settle_q - 1'b1;
            fault_q <= miss || (fault_q && !clr_i);
        end
    end

    assign fault_o = fault_q;

    // R6: a new fault needs an expired window and a real disagreement
    p_fault_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_q) |-> ($past(settle_q) == '0) && ($past(pos_i) != $past(cmd_i)));
    // R7: only a clear can drop a fault bit
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(fault_q) && !$past(clr_i)) |-> fault_q);
endmodule

// File: rtl/relay_bit_ctrl.sv
module relay_bit_ctrl import relay_pkg::*; #(
    parameter drive_mode_e MODE       = DRIVE_LEVEL,
    parameter int          DEB_CYC    = 2000,
    parameter int          SETTLE_CYC = 60000,
    parameter int          PULSE_CYC  = 25000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic [1:0]           rd_addr,
    output logic [WORD_W-1:0]    rd_data,
    input  logic [NUM_CH-1:0]    aux_in,
    output logic [NUM_CH-1:0]    coil_set,
    output logic [NUM_CH-1:0]    coil_rst,
    output logic                 irq
);
    reg_sel_e          wr_sel, rd_sel;
    chan_view_t        view;
    logic [NUM_CH-1:0] cmd_hold_q, cmd_act_q, inten_q;
    logic [NUM_CH-1:0] chg, clr, pos, fault;
    logic              xfer_q;
    logic [WORD_W-1:0] rd_q, rd_d;

    assign wr_sel = reg_sel_e'(wr_addr);
    assign rd_sel = reg_sel_e'(rd_addr);

    assign view.cmd   = cmd_act_q;
    assign view.pos   = pos;
    assign view.fault = fault;
    assign view.inten = inten_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_hold_q <= '0;
            cmd_act_q  <= '0;
            inten_q    <= '0;
            xfer_q     <= 1'b0;
            rd_q       <= '0;
        end else begin
            xfer_q <= wr_en && (wr_sel == REG_CMD);
            if (wr_en && wr_sel == REG_CMD)
                cmd_hold_q <= wr_data[NUM_CH-1:0];
            if (xfer_q)
                cmd_act_q <= cmd_hold_q;
            if (wr_en && wr_sel == REG_INTEN)
                inten_q <= wr_data[NUM_CH-1:0];
            rd_q <= rd_d;
        end
    end

    always_comb begin
        unique case (rd_sel)
            REG_CMD:   rd_d = widen(view.cmd);
            REG_STATE: rd_d = widen(view.pos);
            REG_FAULT: rd_d = widen(view.fault);
            default:   rd_d = widen(view.inten);
        endcase
    end

    assign chg = xfer_q ? (cmd_hold_q ^ cmd_act_q) : '0;
    assign clr = (wr_en && wr_sel == REG_FAULT) ? wr_data[NUM_CH-1:0] : '0;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            relay_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
                .clk(clk), .rst(rst), .raw_i(aux_in[c]), .pos_o(pos[c]));
            relay_coil_drv #(.MODE(MODE), .PULSE_CYC(PULSE_CYC)) u_drv (
                .clk(clk), .rst(rst), .cmd_i(cmd_act_q[c]), .chg_i(chg[c]),
                .new_i(cmd_hold_q[c]), .set_o(coil_set[c]), .rst_o(coil_rst[c]));
            relay_bit_chan #(.SETTLE_CYC(SETTLE_CYC)) u_bit (
                .clk(clk), .rst(rst), .chg_i(chg[c]), .cmd_i(cmd_act_q[c]),
                .pos_i(pos[c]), .clr_i(clr[c]), .fault_o(fault[c]));
        end
    endgenerate

    assign rd_data = rd_q;
    assign irq     = |(view.fault & view.inten);

    // R10: the two coil drives of a channel never overlap
    p_coil_excl_r10: assert property (@(posedge clk) disable iff (rst)
        (coil_set & coil_rst) == '0);
    // R9: the active command only moves on the cycle after a command write
    p_cmd_xfer_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmd_act_q) |-> $past(xfer_q));
endmodule

// File: tb/test_relay_bit_ctrl.sv
module test_relay_bit_ctrl;
    import relay_pkg::*;

    localparam int DEB = 4;
    localparam int SET = 12;
    localparam int PUL = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [1:0]  rd_addr = 2'd0;
    logic [3:0]  aux = 4'h0;
    logic [15:0] rd_n, rd_l;
    logic [3:0]  cs_n, cr_n, cs_l, cr_l;
    logic        irq_n, irq_l;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    relay_bit_ctrl #(.MODE(DRIVE_LEVEL), .DEB_CYC(DEB), .SETTLE_CYC(SET), .PULSE_CYC(PUL))
    i_relay_bit_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_n), .aux_in(aux), .coil_set(cs_n),
        .coil_rst(cr_n), .irq(irq_n));

    relay_bit_ctrl #(.MODE(DRIVE_PULSE), .DEB_CYC(DEB), .SETTLE_CYC(SET), .PULSE_CYC(PUL))
    i_relay_bit_ctrl_lat (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_l), .aux_in(aux), .coil_set(cs_l),
        .coil_rst(cr_l), .irq(irq_l));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        d = rd_n;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] d;
        logic [3:0]  prev;
        int          ns [4];
        int          nr [4];

        idle(4);
        rst = 1'b0;
        // R2/R3: reset state of both drive styles, no start-up pulse
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i == 0) begin
                check("R2 coil_set after reset", cs_n, 0);
                check("R2 coil_rst after reset", cr_n, 0);
            end
            check("R3 no pulse after reset", {cs_l, cr_l}, 0);
        end
        rd(2'd0, d); check("R1 cmd after reset", d, 0);
        rd(2'd2, d); check("R7 fault after reset", d, 0);
        check("R8 irq after reset", irq_n, 0);

        // R5/R4: every contact pattern reaches the position register
        for (int a = 0; a < 16; a++) begin
            aux = 4'(a);
            idle(DEB + 4);
            rd(2'd1, d);
            check("R5 position readback", d, 16'(a));
        end
        aux = 4'h0;
        idle(DEB + 4);
        wr(2'd2, 16'hFFFF);
        rd(2'd2, d); check("R7 clear all", d, 0);

        // R4: a bounce shorter than the filter is ignored
        @(negedge clk); aux[2] = 1'b1;
        idle(DEB - 2);
        aux[2] = 1'b0;
        idle(DEB + 6);
        rd(2'd1, d); check("R4 bounce ignored", d, 0);
        rd(2'd2, d); check("R4 bounce gives no fault", d, 0);

        // R1/R2/R3/R9: sweep every command pattern with junk in upper bits
        prev = 4'h0;
        for (int v = 0; v < 16; v++) begin
            for (int c = 0; c < 4; c++) begin ns[c] = 0; nr[c] = 0; end
            wr(2'd0, 16'(((v * 37 + 5) & 16'hFFF) << 4) | 16'(v));
            aux = 4'(v);
            check("R9 holding stage delays output", cs_n, 32'(prev));
            for (int i = 0; i < PUL + 6; i++) begin
                @(negedge clk);
                if (i == 0) check("R2 level drive follows command", cs_n, v);
                check("R2 no reset drive in level mode", cr_n, 0);
                for (int c = 0; c < 4; c++) begin
                    ns[c] += int'(cs_l[c]);
                    nr[c] += int'(cr_l[c]);
                end
            end
            for (int c = 0; c < 4; c++) begin
                check("R3 set pulse width", ns[c], (v[c] && !prev[c]) ? PUL : 0);
                check("R3 reset pulse width", nr[c], (!v[c] && prev[c]) ? PUL : 0);
            end
            rd(2'd0, d); check("R1 command readback", d, v);
            idle(SET);
            prev = 4'(v);
        end
        rd(2'd2, d); check("R6 no fault when contacts follow", d, 0);

        // R3: rewriting the same value gives no pulse
        for (int c = 0; c < 4; c++) begin ns[c] = 0; nr[c] = 0; end
        wr(2'd0, 16'h000F);
        for (int i = 0; i < PUL + 6; i++) begin
            @(negedge clk);
            for (int c = 0; c < 4; c++) begin
                ns[c] += int'(cs_l[c]);
                nr[c] += int'(cr_l[c]);
            end
        end
        check("R3 unchanged rewrite set", ns[0] + ns[1] + ns[2] + ns[3], 0);
        check("R3 unchanged rewrite reset", nr[0] + nr[1] + nr[2] + nr[3], 0);

        // R6/R8: mismatch on enabled channel 2 and masked channel 1
        wr(2'd3, 16'h0002);
        check("R8 irq quiet without fault", irq_n, 0);
        aux[1] = 1'b0;
        idle(DEB + 8);
        rd(2'd2, d); check("R6 fault on channel 2", d, 16'h0002);
        check("R8 irq on enabled fault", irq_n, 1);
        aux[0] = 1'b0;
        idle(DEB + 8);
        rd(2'd2, d); check("R6 fault on channels 1 and 2", d, 16'h0003);
        wr(2'd3, 16'h0000);
        check("R8 irq masked", irq_n, 0);
        wr(2'd3, 16'hFFF1);
        check("R8 irq from channel 1", irq_n, 1);
        rd(2'd3, d); check("R8 enable readback", d, 16'h0001);

        // R7: write of zero keeps faults, write of one clears
        wr(2'd2, 16'h0000);
        rd(2'd2, d); check("R7 zero write keeps faults", d, 16'h0003);
        wr(2'd2, 16'h0001);
        idle(2);
        rd(2'd2, d); check("R7 live fault sets again", d, 16'h0003);
        aux = 4'hF;
        idle(DEB + 6);
        wr(2'd2, 16'h0001);
        rd(2'd2, d); check("R7 clear channel 1 only", d, 16'h0002);
        wr(2'd2, 16'h0002);
        rd(2'd2, d); check("R7 clear channel 2", d, 0);
        check("R8 irq drops after clear", irq_n, 0);

        // R6: contact follows late but inside the settle window
        wr(2'd0, 16'h0000);
        idle(4);
        aux = 4'h0;
        idle(SET + DEB + 10);
        rd(2'd2, d); check("R6 late follow inside window", d, 0);

        // R6: contact never follows; quiet in window, fault after it
        wr(2'd0, 16'h0008);
        idle(SET - 6);
        rd(2'd2, d); check("R6 suppressed during window", d, 0);
        idle(SET + 6);
        rd(2'd2, d); check("R6 fault after window", d, 16'h0008);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule